// File: doc/BRIEF.md
# Center-Aligned Timer Counter with Update Control

This block is the time base of a timer that counts up and down symmetrically. A prescaler turns the system clock into a count enable. The counter climbs from 0 to one below the auto-reload value, reverses, falls back to 0 and reverses again. The turn at the top is an overflow event and the turn at the bottom is an underflow event. The counting direction is an output owned by hardware.

Software writes preload values for the prescaler divider and the auto-reload limit. These values only take effect when an update event moves them into the shadow registers. Update events come from two places. The first is the counter, which issues one after a programmed number of overflow/underflow events set by an unbuffered repetition count. The second is a software update-generate strobe, which also restarts the counter and the prescaler. An update-disable bit blocks update events altogether. An update-source bit keeps strobe-caused updates out of the sticky update flag.

Register writes use a simple port with `wr_en`, a 2-bit address and data:
- Address 0: prescaler preload.
- Address 1: auto-reload preload.
- Address 2: repetition count.
- Address 3: control. Bit 0 is update-disable, bit 1 is update-source select, and bit 2 is the update-generate strobe. The strobe is not stored. A strobe acts with the disable and source bits written in the same write.

Top module: `ca_timer`

## Requirements
- R1: After reset, `cnt` is 0, `dir_down` is 0, `upd_pulse` and `upd_flag` are 0, the prescaler shadow is 0 and the auto-reload shadow holds the all-ones reset value. With these values the counter advances by one on every clock.
- R2: With prescaler shadow P, the counter changes only once every P+1 clock cycles, counted from the last restart.
- R3: With auto-reload shadow A (values below 2 act as 2), the count runs 0, 1, … A-1 with `dir_down`=0. It then falls A-2 … 0 with `dir_down`=1, then rises 1 … A-1 with `dir_down`=0, and repeats this cycle.
- R4: Each step away from A-1 while rising (overflow) and each step away from 0 while falling (underflow) is one event. With repetition count R, every (R+1)-th event is an update event. The repetition down-counter is reloaded with R on every update and on the strobe.
- R5: A control write with bit 2 set clears `cnt` to 0, sets the direction to up and restarts the prescaler from 0. Unless bit 0 of the same write is set, it also causes an update event.
- R6: While update-disable (control bit 0) is 1, `upd_pulse` stays 0, the flag is not set and neither shadow is loaded. The counter keeps running with the current shadows.
- R7: A repetition count written while updates are disabled is used at the next reload of the repetition down-counter, with no update needed.
- R8: If control bit 1 is 1, an update caused by the strobe does not set `upd_flag`. Counter-caused updates always set it, and a strobe with bit 1 at 0 also sets it.
- R9: On each update event, both shadows are loaded from their preloads. The period that follows uses the new auto-reload value.
- R10: `upd_pulse` is high for the one cycle after each update event. `upd_flag` stays 1 until `flag_clr` is asserted, and a new set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 prescaler, 1 auto-reload, 2 repetition, 3 control) |
| wr_data | input | DATA_W | Write data |
| flag_clr | input | 1 | Clears the update flag |
| cnt | output | CNT_W | Current count |
| dir_down | output | 1 | 1 while counting down |
| upd_pulse | output | 1 | One-cycle update event pulse |
| upd_flag | output | 1 | Sticky update flag |

## Verification
On every cycle, the assertions check the following:
- The count and direction hold between prescaler ticks.
- A falling count drops by exactly one per tick.
- The direction turns at the top.
- The prescaler count never passes its shadow.
- No update is issued while updates are disabled, or while the repetition down-counter is nonzero.
- A silent strobe does not raise the flag, and the flag holds until it is cleared.

Only the bench scenarios can show whether the shadows hold old values while updates are disabled and change after an update. The same applies to the spacing of update pulses under a given repetition count, to the use of a repetition count written during disable, and to the full count waveform across a sweep of divider, limit and repetition settings.

// File: rtl/ca_timer_pkg.sv
// Package: shared register addresses and control bit positions for ca_timer.
// Assumes a 2-bit register address on the write port.
package ca_timer_pkg;
    typedef enum logic [1:0] {
        REG_PSC  = 2'd0,
        REG_ARR  = 2'd1,
        REG_REP  = 2'd2,
        REG_CTRL = 2'd3
    } reg_addr_e;

    localparam int CTL_UDIS = 0;
    localparam int CTL_URS  = 1;
    localparam int CTL_UG   = 2;
endpackage

// File: rtl/ca_psc.sv
// Prescaler: counts 0..psc_sh and raises tick in the cycle it sits at psc_sh,
// so the count enable fires once every psc_sh+1 cycles. A restart forces the
// count to 0 and suppresses the tick. Assumes psc_sh changes only at a wrap
// or a restart.
module ca_psc #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc_sh,
    output logic             tick
);
    logic [PSC_W-1:0] pc_q;
    logic             wrap;

    assign wrap = (pc_q == psc_sh);
    assign tick = wrap && !restart;

    // Divider count: wrap at the shadow value or restart on request.
    always_ff @(posedge clk) begin
        if (!rst_n)               pc_q <= '0;
        else if (restart || wrap) pc_q <= '0;
        else                      pc_q <= pc_q + 1'b1;
    end

    AST_PSC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= psc_sh);  // R2
endmodule

// File: rtl/ca_updown.sv
// Center-aligned up/down counter. It steps once per tick. While rising, the
// step away from the top (limit-1) is an overflow and the count turns down.
// While falling, the step away from 0 is an underflow and the count turns up.
// A limit below 2 acts as 2. A restart clears the count and sets the
// direction to up.
module ca_updown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] arr_sh,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             ovf,
    output logic             unf
);
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic [CNT_W-1:0] top;
    logic             at_top;
    logic             at_bot;

    // Highest value of the count for the current limit.
    assign top    = (arr_sh < CNT_W'(2)) ? CNT_W'(1) : arr_sh - 1'b1;
    assign at_top = !dir_q && (cnt_q >= top);
    assign at_bot = dir_q && (cnt_q == '0);
    assign ovf    = tick && at_top;
    assign unf    = tick && at_bot;
    assign cnt      = cnt_q;
    assign dir_down = dir_q;

    // Count and direction: step on tick, turn at the ends, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (tick) begin
            if (at_top) begin
                dir_q <= 1'b1;
                cnt_q <= top - 1'b1;
            end else if (at_bot) begin
                dir_q <= 1'b0;
                cnt_q <= CNT_W'(1);
            end else if (dir_q) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> ($stable(cnt_q) && $stable(dir_q)));  // R2
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && dir_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));  // R3
    AST_TURN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && !dir_q && cnt_q >= top) |=> dir_q);  // R3
endmodule

// File: rtl/ca_upd_ctrl.sv
// Update control. A repetition down-counter turns overflow/underflow events
// into counter updates. The strobe and the disable bit gate them into update
// events. Shadows load on accepted updates, the pulse is registered and the
// flag is sticky. Assumes ev never coincides with ug (the restart masks tick).
module ca_upd_ctrl #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int REP_W = 8,
    parameter logic [CNT_W-1:0] ARR_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic             ug,
    input  logic             udis,
    input  logic             urs,
    input  logic             flag_clr,
    input  logic [REP_W-1:0] rep_val,
    input  logic [PSC_W-1:0] psc_pre,
    input  logic [CNT_W-1:0] arr_pre,
    output logic [PSC_W-1:0] psc_sh,
    output logic [CNT_W-1:0] arr_sh,
    output logic             upd_pulse,
    output logic             upd_flag
);
    logic [REP_W-1:0] rep_q;
    logic             cu;
    logic             upd;
    logic             set_flag;

    assign cu       = ev && (rep_q == '0);
    assign upd      = (cu || ug) && !udis;
    assign set_flag = upd && !(ug && urs);

    // Repetition down-counter: reload from the live count, else step per event.
    always_ff @(posedge clk) begin
        if (!rst_n)        rep_q <= '0;
        else if (ug || cu) rep_q <= rep_val;
        else if (ev)       rep_q <= rep_q - 1'b1;
    end

    // Shadow registers: take the preloads on accepted updates only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_sh <= '0;
            arr_sh <= ARR_RST;
        end else if (upd) begin
            psc_sh <= psc_pre;
            arr_sh <= arr_pre;
        end
    end

    // Pulse and sticky flag; a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_pulse <= 1'b0;
            upd_flag  <= 1'b0;
        end else begin
            upd_pulse <= upd;
            if (set_flag)      upd_flag <= 1'b1;
            else if (flag_clr) upd_flag <= 1'b0;
        end
    end

    AST_NO_UPD_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        udis |=> !upd_pulse);  // R6
    AST_REP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && rep_q != '0 && !ug) |=> !upd_pulse);  // R4
    AST_URS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ug && urs && !cu && !upd_flag) |=> !upd_flag);  // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag && !flag_clr) |=> upd_flag);  // R10
endmodule

// File: rtl/ca_timer.sv
// Top of the center-aligned timer. It holds the preload and control
// registers behind the write port and ties together the prescaler, the
// up/down counter and the update control. The strobe bit of a control write
// acts with the disable and source bits written by that same write.
// Assumes DATA_W >= CNT_W, PSC_W and REP_W.
module ca_timer
    import ca_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int REP_W  = 8,
    parameter int DATA_W = 16,
    parameter logic [CNT_W-1:0] ARR_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  cnt,
    output logic              dir_down,
    output logic              upd_pulse,
    output logic              upd_flag
);
    logic [PSC_W-1:0] psc_pre;
    logic [CNT_W-1:0] arr_pre;
    logic [REP_W-1:0] rep_val;
    logic             udis_q;
    logic             urs_q;
    logic             ctrl_wr;
    logic             ug;
    logic             udis_eff;
    logic             urs_eff;
    logic             tick;
    logic             ovf;
    logic             unf;
    logic [PSC_W-1:0] psc_sh;
    logic [CNT_W-1:0] arr_sh;

    assign ctrl_wr  = wr_en && (reg_addr_e'(wr_addr) == REG_CTRL);
    assign ug       = ctrl_wr && wr_data[CTL_UG];
    assign udis_eff = ctrl_wr ? wr_data[CTL_UDIS] : udis_q;
    assign urs_eff  = ctrl_wr ? wr_data[CTL_URS]  : urs_q;

    // Register file: preloads, repetition count and stored control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_pre <= '0;
            arr_pre <= ARR_RST;
            rep_val <= '0;
            udis_q  <= 1'b0;
            urs_q   <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_PSC:  psc_pre <= wr_data[PSC_W-1:0];
                REG_ARR:  arr_pre <= wr_data[CNT_W-1:0];
                REG_REP:  rep_val <= wr_data[REP_W-1:0];
                REG_CTRL: begin
                    udis_q <= wr_data[CTL_UDIS];
                    urs_q  <= wr_data[CTL_URS];
                end
                default: ;
            endcase
        end
    end

    ca_psc #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ug),
        .psc_sh  (psc_sh),
        .tick    (tick)
    );

    ca_updown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (ug),
        .tick     (tick),
        .arr_sh   (arr_sh),
        .cnt      (cnt),
        .dir_down (dir_down),
        .ovf      (ovf),
        .unf      (unf)
    );

    ca_upd_ctrl #(
        .CNT_W   (CNT_W),
        .PSC_W   (PSC_W),
        .REP_W   (REP_W),
        .ARR_RST (ARR_RST)
    ) u_upd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ovf || unf),
        .ug        (ug),
        .udis      (udis_eff),
        .urs       (urs_eff),
        .flag_clr  (flag_clr),
        .rep_val   (rep_val),
        .psc_pre   (psc_pre),
        .arr_pre   (arr_pre),
        .psc_sh    (psc_sh),
        .arr_sh    (arr_sh),
        .upd_pulse (upd_pulse),
        .upd_flag  (upd_flag)
    );
endmodule

// File: tb/tb_ca_timer.sv
// Bench for ca_timer: a sweep of divider, limit and repetition settings
// against an arithmetic model, then directed runs for the strobe, the flag
// and the disable controls.
module tb_ca_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] cnt;
    logic        dir_down;
    logic        upd_pulse;
    logic        upd_flag;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ca_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flag_clr(flag_clr), .cnt(cnt),
        .dir_down(dir_down), .upd_pulse(upd_pulse), .upd_flag(upd_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: drive inputs now (at a falling edge), return at the next falling edge.
    task automatic cyc(input bit we, input logic [1:0] a, input logic [15:0] d, input bit fc);
        wr_en = we; wr_addr = a; wr_data = d; flag_clr = fc;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; flag_clr = 1'b0;
    endtask

    // Expected outputs m edges after a strobe, for divider P, limit A, repetition R.
    task automatic model(input int m, input int p, input int a, input int r,
                         output int ec, output int ed, output int ep);
        int n, t, q;
        n = m / (p + 1);
        t = 2 * (a - 1);
        if (n == 0) begin
            ec = 0; ed = 0;
        end else begin
            q = (n - 1) % t;
            if (q <= a - 2) begin ec = q + 1; ed = 0; end
            else begin ec = t - 1 - q; ed = 1; end
        end
        ep = ((m == 0) || ((m % (p + 1) == 0) && n > 1 &&
              ((n - 1) % ((r + 1) * (a - 1)) == 0))) ? 1 : 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int ec, ed, ep, ef, mx, gap, k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset cnt", cnt, 0);
        chk("R1", "reset dir", dir_down, 0);
        chk("R1", "reset pulse", upd_pulse, 0);
        chk("R1", "reset flag", upd_flag, 0);
        rst_n = 1'b1;
        repeat (5) cyc(0, 0, 0, 0);
        chk("R1", "count after 5 clocks with reset shadows", cnt, 5);

        // Sweep: divider, limit and repetition; the strobe loads the shadows.
        for (int p = 0; p <= 2; p++) begin
            for (int a = 2; a <= 5; a++) begin
                for (int r = 0; r <= 2; r++) begin
                    cyc(1, 2'd0, 16'(p), 0);
                    cyc(1, 2'd1, 16'(a), 0);
                    cyc(1, 2'd2, 16'(r), 0);
                    cyc(1, 2'd3, 16'b110, 1);  // strobe, silent flag, clear flag
                    ef = 0;
                    for (int m = 0; m <= 2 * (r + 1) * (a - 1) * (p + 1) + 3 * (p + 1) + 2; m++) begin
                        model(m, p, a, r, ec, ed, ep);
                        if (ep == 1 && m > 0) ef = 1;
                        chk("R2 R3", "sweep cnt", cnt, ec);
                        chk("R3", "sweep dir", dir_down, ed);
                        chk("R4 R5", "sweep pulse", upd_pulse, ep);
                        chk("R8", "sweep flag", upd_flag, ef);
                        cyc(0, 0, 0, 0);
                    end
                end
            end
        end

        // Strobe without silent bit sets the flag; clear; silent strobe; counter update.
        cyc(1, 2'd0, 16'd0, 0);
        cyc(1, 2'd1, 16'd3, 0);
        cyc(1, 2'd2, 16'd0, 0);
        cyc(1, 2'd3, 16'b100, 1);
        chk("R8", "strobe sets flag, set wins over clear", upd_flag, 1);
        chk("R10", "set wins over clear", upd_flag, 1);
        chk("R5", "strobe pulse", upd_pulse, 1);
        chk("R5", "strobe clears cnt", cnt, 0);
        cyc(0, 0, 0, 1);
        chk("R10", "flag cleared", upd_flag, 0);
        cyc(1, 2'd3, 16'b110, 0);
        chk("R8", "silent strobe pulse", upd_pulse, 1);
        chk("R8", "silent strobe leaves flag", upd_flag, 0);
        repeat (3) cyc(0, 0, 0, 0);
        chk("R4", "counter update pulse", upd_pulse, 1);
        chk("R8", "counter update sets flag", upd_flag, 1);
        cyc(0, 0, 0, 0);
        chk("R10", "pulse lasts one cycle", upd_pulse, 0);
        chk("R10", "flag stays set", upd_flag, 1);

        // Disable: new preloads and repetition written, nothing updates.
        cyc(1, 2'd3, 16'b001, 0);
        cyc(1, 2'd1, 16'd6, 0);
        cyc(1, 2'd0, 16'd1, 0);
        cyc(1, 2'd2, 16'd1, 0);
        cyc(0, 0, 0, 1);
        mx = 0; k = 0;
        for (int i = 0; i < 20; i++) begin
            if (int'(cnt) > mx) mx = int'(cnt);
            if (upd_pulse) k++;
            cyc(0, 0, 0, 0);
        end
        chk("R6", "pulses while disabled", k, 0);
        chk("R6", "peak keeps old limit", mx, 2);
        chk("R6", "flag while disabled", upd_flag, 0);
        cyc(1, 2'd3, 16'b000, 0);
        // Wait for the second pulse after re-enable, then time the next interval.
        k = 0;
        for (int i = 0; i < 200 && k < 2; i++) begin
            if (upd_pulse) k++;
            if (k < 2) cyc(0, 0, 0, 0);
        end
        chk("R6", "updates resume", k, 2);
        cyc(0, 0, 0, 0);
        gap = 1; mx = 0;
        for (int i = 0; i < 200 && !upd_pulse; i++) begin
            if (int'(cnt) > mx) mx = int'(cnt);
            cyc(0, 0, 0, 0);
            gap++;
        end
        chk("R7", "update spacing with repetition 1, limit 6, divider 2", gap, 20);
        chk("R9", "peak uses new limit", mx, 5);
        chk("R9", "flag after counter update", upd_flag, 1);

        // Strobe with disable: restart only, shadows keep limit 6.
        cyc(1, 2'd1, 16'd4, 0);
        cyc(1, 2'd3, 16'b101, 0);
        chk("R5", "disabled strobe clears cnt", cnt, 0);
        chk("R5", "disabled strobe dir up", dir_down, 0);
        chk("R6", "disabled strobe no pulse", upd_pulse, 0);
        cyc(0, 0, 0, 0);
        chk("R2", "no step after one clock with divider 2", cnt, 0);
        cyc(0, 0, 0, 0);
        chk("R2", "step after two clocks", cnt, 1);
        mx = 0;
        for (int i = 0; i < 30; i++) begin
            if (int'(cnt) > mx) mx = int'(cnt);
            cyc(0, 0, 0, 0);
        end
        chk("R6", "shadow limit not loaded by disabled strobe", mx, 5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule